// File: doc/BRIEF.md
# FP64 Normalized Mantissa Extractor

This unit takes one IEEE-754 double-precision operand and a 4-bit control word. It returns a double whose 52-bit fraction is the operand's normalized fraction, with the exponent rewritten so that the magnitude lands inside one of four intervals. The low two control bits pick the interval. The upper two control bits decide the result sign and whether a negative operand is rejected as invalid.

Special operands bypass the rescaling. NaNs come back quieted. Zeros and infinities become plus or minus one. A rejected negative becomes the default quiet NaN, 0xFFF8_0000_0000_0000. Subnormals are normalized in a single step with a leading-zero count and a barrel shift, unless the denormals-as-zero input is high, in which case they are treated as zero.

The classification and rescaling logic is combinational. The result and the two flags are registered one cycle after an accepted operand.

Top module: `fp64_mant_norm`

## Requirements
- R1: `outValid` is high exactly one cycle after `inValid` was high and low otherwise. `result`, `invalidFlag` and `denormFlag` are captured on that same edge, and both flags are low whenever `outValid` is low. A synchronous active-high reset clears every output to 0.
- R2: For a finite rescaled operand, interval code `ctrl[1:0]`=00 gives result exponent field 1023. The 52-bit fraction is passed through unchanged.
- R3: For interval code 01, the exponent field is 1022 when the operand's unbiased exponent (after any normalization) is odd, and 1023 when it is even.
- R4: For interval code 10, the exponent field is always 1022.
- R5: For interval code 11, the exponent field is 1022 when the top bit of the normalized fraction (bit 51) is 1, and 1023 when it is 0.
- R6: On a rescaled result, `ctrl[2]`=1 forces the sign bit (bit 63) to 0. With `ctrl[2]`=0 the operand's sign is kept.
- R7: With `ctrl[3]`=1, a negative infinity or negative nonzero finite operand returns 0xFFF8_0000_0000_0000 and raises `invalidFlag`. A negative subnormal rejected this way does not raise `denormFlag`.
- R8: A NaN operand (exponent all ones, fraction nonzero) returns the operand with fraction bit 51 set. `invalidFlag` is raised only if that bit was 0 in the operand. Interval and sign-control bits have no effect.
- R9: Positive zero and positive infinity return +1.0 (0x3FF0_0000_0000_0000). Negative zero, and negative infinity when `ctrl[3]`=0, return +1.0 when `ctrl[2]`=1 and -1.0 (0xBFF0_0000_0000_0000) when `ctrl[2]`=0. The interval code is ignored, and negative zero never raises `invalidFlag`.
- R10: When `dazMode`=0, a subnormal operand is normalized: it is shifted left until its leading 1 leaves bit 51, and its biased exponent becomes 1023 minus the shift count. `denormFlag` is raised and the normalized value is then rescaled as in R2 to R5.
- R11: When `dazMode`=1, a subnormal operand is treated as a zero of its sign (R9), and `denormFlag` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand and control are valid this cycle |
| operand | input | 64 | IEEE-754 double-precision input |
| ctrl | input | 4 | [1:0] interval code, [2] force positive, [3] reject negatives |
| dazMode | input | 1 | Treat subnormal operands as zero |
| outValid | output | 1 | Registered result valid |
| result | output | 64 | Rescaled mantissa or special value |
| invalidFlag | output | 1 | Invalid-operation flag for this result |
| denormFlag | output | 1 | Subnormal operand was normalized |

## Verification
The assertions take for granted that `inValid` is held low while reset is high. They also assume that `operand`, `ctrl` and `dazMode` are driven to known values whenever `inValid` is high, because the classification strobes are checked for exactly one selected path on every accepted cycle.

The stimulus applies reset with `inValid` low and changes inputs only on the falling edge. It drops `inValid` between operands, so every result is checked in isolation and the idle state of the flags is observed as well.

// File: rtl/fpmant_pkg.sv
package fpmant_pkg;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SHIFT_W = $clog2(FRAC_W + 1);
  localparam logic [EXP_W-1:0] BIAS = EXP_W'((1 << (EXP_W - 1)) - 1);
  localparam logic [WORD_W-1:0] ONE_POS = {1'b0, BIAS, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] QNAN_DEFAULT = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic pickNan;
    logic pickOne;
    logic pickIndef;
    logic pickMant;
    logic oneNeg;
    logic useSub;
    logic mantSign;
    logic raiseInv;
    logic raiseDen;
  } strobe_t;
endpackage

// File: rtl/fpmant_ctrl.sv
module fpmant_ctrl
  import fpmant_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] operand,
  input  logic [3:0]        ctrl,
  input  logic              dazMode,
  output strobe_t           strobes
);
  logic              opSign;
  logic [EXP_W-1:0]  opExp;
  logic [FRAC_W-1:0] opFrac;
  logic expZero, expMax, fracZero;
  logic isNan, isInf, isZero, isSub;

  assign opSign   = operand[WORD_W-1];
  assign opExp    = operand[WORD_W-2 -: EXP_W];
  assign opFrac   = operand[FRAC_W-1:0];
  assign expZero  = (opExp == '0);
  assign expMax   = &opExp;
  assign fracZero = (opFrac == '0);
  assign isNan    = expMax && !fracZero;
  assign isInf    = expMax && fracZero;
  assign isZero   = expZero && (fracZero || dazMode);
  assign isSub    = expZero && !fracZero && !dazMode;

  always_comb begin
    strobes = '0;
    strobes.mantSign = ctrl[2] ? 1'b0 : opSign;
    if (isNan) begin
      strobes.pickNan  = 1'b1;
      strobes.raiseInv = !opFrac[FRAC_W-1];
    end else if (!opSign && (isZero || isInf)) begin
      strobes.pickOne = 1'b1;
    end else if (opSign && isZero) begin
      strobes.pickOne = 1'b1;
      strobes.oneNeg  = !ctrl[2];
    end else if (opSign && ctrl[3]) begin
      strobes.pickIndef = 1'b1;
      strobes.raiseInv  = 1'b1;
    end else if (opSign && isInf) begin
      strobes.pickOne = 1'b1;
      strobes.oneNeg  = !ctrl[2];
    end else begin
      strobes.pickMant = 1'b1;
      strobes.useSub   = isSub;
      strobes.raiseDen = isSub;
    end
  end

  // R9: exactly one output path is selected for an accepted operand
  p_one_path_r9: assert property (@(posedge clk) disable iff (rst)
    inValid |-> $onehot({strobes.pickNan, strobes.pickOne, strobes.pickIndef, strobes.pickMant}));

  // R7: a rejected negative never reports a subnormal
  p_indef_no_den_r7: assert property (@(posedge clk) disable iff (rst)
    (inValid && strobes.pickIndef) |-> !strobes.raiseDen);
endmodule

// File: rtl/fpmant_dpath.sv
module fpmant_dpath
  import fpmant_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] operand,
  input  logic [1:0]        interval,
  input  strobe_t           strobes,
  output logic              outValid,
  output logic [WORD_W-1:0] result,
  output logic              invalidFlag,
  output logic              denormFlag
);
  logic [FRAC_W-1:0]  rawFrac;
  logic [SHIFT_W-1:0] leadZeros;
  logic [SHIFT_W-1:0] shAmt;
  logic [FRAC_W-1:0]  normFrac;
  logic [EXP_W-1:0]   normExp;
  logic               expOdd;
  logic [EXP_W-1:0]   outExp;
  logic [WORD_W-1:0]  nextResult;

  assign rawFrac = operand[FRAC_W-1:0];

  always_comb begin
    leadZeros = SHIFT_W'(FRAC_W);
    for (int b = 0; b < FRAC_W; b++) begin
      if (rawFrac[b]) leadZeros = SHIFT_W'(FRAC_W - 1 - b);
    end
  end

  assign shAmt    = leadZeros + SHIFT_W'(1);
  assign normFrac = strobes.useSub ? (rawFrac << shAmt) : rawFrac;
  assign normExp  = strobes.useSub ? (BIAS - EXP_W'(shAmt)) : operand[WORD_W-2 -: EXP_W];
  // unbiased exponent parity: the bias is odd, so parity flips
  assign expOdd   = ~normExp[0];

  always_comb begin
    unique case (interval)
      2'b00:   outExp = BIAS;
      2'b01:   outExp = expOdd ? BIAS - EXP_W'(1) : BIAS;
      2'b10:   outExp = BIAS - EXP_W'(1);
      default: outExp = normFrac[FRAC_W-1] ? BIAS - EXP_W'(1) : BIAS;
    endcase
  end

  always_comb begin
    if (strobes.pickNan)
      nextResult = operand | (WORD_W'(1) << (FRAC_W - 1));
    else if (strobes.pickIndef)
      nextResult = QNAN_DEFAULT;
    else if (strobes.pickOne)
      nextResult = {strobes.oneNeg, ONE_POS[WORD_W-2:0]};
    else
      nextResult = {strobes.mantSign, outExp, normFrac};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid    <= 1'b0;
      result      <= '0;
      invalidFlag <= 1'b0;
      denormFlag  <= 1'b0;
    end else begin
      outValid    <= inValid;
      invalidFlag <= inValid && strobes.raiseInv;
      denormFlag  <= inValid && strobes.raiseDen;
      if (inValid) result <= nextResult;
    end
  end

  // R1: the result appears one cycle after an accepted operand
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !invalidFlag && !denormFlag));

  // R2: any non-NaN, non-infinite result has exponent at the bias or one below
  p_exp_window_r2: assert property (@(posedge clk) disable iff (rst)
    (outValid && !(&result[WORD_W-2 -: EXP_W])) |->
      (result[WORD_W-2 -: EXP_W] == BIAS || result[WORD_W-2 -: EXP_W] == BIAS - EXP_W'(1)));

  // R8: an invalid result is always a quiet NaN
  p_invalid_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (outValid && invalidFlag) |-> ((&result[WORD_W-2 -: EXP_W]) && result[FRAC_W-1]));

  // R10: the denormal flag only accompanies a rescaled, valid result
  p_den_excl_r10: assert property (@(posedge clk) disable iff (rst)
    denormFlag |-> (outValid && !invalidFlag));
endmodule

// File: rtl/fp64_mant_norm.sv
module fp64_mant_norm
  import fpmant_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] operand,
  input  logic [3:0]        ctrl,
  input  logic              dazMode,
  output logic              outValid,
  output logic [WORD_W-1:0] result,
  output logic              invalidFlag,
  output logic              denormFlag
);
  strobe_t strobes;

  fpmant_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .operand (operand),
    .ctrl    (ctrl),
    .dazMode (dazMode),
    .strobes (strobes)
  );

  fpmant_dpath dpath_i (
    .clk         (clk),
    .rst         (rst),
    .inValid     (inValid),
    .operand     (operand),
    .interval    (ctrl[1:0]),
    .strobes     (strobes),
    .outValid    (outValid),
    .result      (result),
    .invalidFlag (invalidFlag),
    .denormFlag  (denormFlag)
  );
endmodule

// File: tb/fp64_mant_norm_tb.sv
module fp64_mant_norm_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [63:0] operand;
  logic [3:0]  ctrl;
  logic        dazMode;
  logic        outValid;
  logic [63:0] result;
  logic        invalidFlag;
  logic        denormFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam logic [63:0] ONE_P = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] ONE_N = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] INDEF = 64'hFFF8_0000_0000_0000;

  always #4 clk = ~clk;

  fp64_mant_norm dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .operand(operand), .ctrl(ctrl),
    .dazMode(dazMode), .outValid(outValid), .result(result),
    .invalidFlag(invalidFlag), .denormFlag(denormFlag)
  );

  task automatic expect_bits(string tag, logic [66:0] act, logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, logic [63:0] op, logic [3:0] c, logic daz,
                       logic [63:0] expRes, logic expInv, logic expDen);
    @(negedge clk);
    inValid = 1'b1; operand = op; ctrl = c; dazMode = daz;
    @(negedge clk);
    inValid = 1'b0;
    expect_bits(tag, {outValid, invalidFlag, denormFlag, result}, {1'b1, expInv, expDen, expRes});
    @(negedge clk);
    expect_bits({tag, " idle R1"}, {outValid, invalidFlag, denormFlag, 64'h0}, 67'h0);
  endtask

  task automatic test_reset();
    rst = 1'b1; inValid = 1'b0; operand = '0; ctrl = '0; dazMode = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_bits("R1 reset", {outValid, invalidFlag, denormFlag, result}, 67'h0);
  endtask

  task automatic test_intervals();
    apply("R2 1.5 int00", 64'h3FF8_0000_0000_0000, 4'b0000, 0, 64'h3FF8_0000_0000_0000, 0, 0);
    apply("R2 6.0 int00", 64'h4018_0000_0000_0000, 4'b0000, 0, 64'h3FF8_0000_0000_0000, 0, 0);
    apply("R3 3.0 odd int01", 64'h4008_0000_0000_0000, 4'b0001, 0, 64'h3FE8_0000_0000_0000, 0, 0);
    apply("R3 6.0 even int01", 64'h4018_0000_0000_0000, 4'b0001, 0, 64'h3FF8_0000_0000_0000, 0, 0);
    apply("R4 1.5 int10", 64'h3FF8_0000_0000_0000, 4'b0010, 0, 64'h3FE8_0000_0000_0000, 0, 0);
    apply("R5 1.5 int11", 64'h3FF8_0000_0000_0000, 4'b0011, 0, 64'h3FE8_0000_0000_0000, 0, 0);
    apply("R5 1.25 int11", 64'h3FF4_0000_0000_0000, 4'b0011, 0, 64'h3FF4_0000_0000_0000, 0, 0);
  endtask

  task automatic test_sign();
    apply("R6 -6.0 keep", 64'hC018_0000_0000_0000, 4'b0000, 0, 64'hBFF8_0000_0000_0000, 0, 0);
    apply("R6 -6.0 force+", 64'hC018_0000_0000_0000, 4'b0100, 0, 64'h3FF8_0000_0000_0000, 0, 0);
    apply("R7 -6.0 reject", 64'hC018_0000_0000_0000, 4'b1000, 0, INDEF, 1, 0);
    apply("R7 -6.0 reject sc11", 64'hC018_0000_0000_0000, 4'b1101, 0, INDEF, 1, 0);
    apply("R7 -inf reject", 64'hFFF0_0000_0000_0000, 4'b1000, 0, INDEF, 1, 0);
    apply("R7 -sub reject", 64'h8008_0000_0000_0000, 4'b1000, 0, INDEF, 1, 0);
  endtask

  task automatic test_nan();
    apply("R8 snan", 64'h7FF0_0000_0000_0001, 4'b0110, 0, 64'h7FF8_0000_0000_0001, 1, 0);
    apply("R8 qnan", 64'hFFF8_0000_0000_1234, 4'b1011, 0, 64'hFFF8_0000_0000_1234, 0, 0);
  endtask

  task automatic test_specials();
    apply("R9 +0", 64'h0000_0000_0000_0000, 4'b0011, 0, ONE_P, 0, 0);
    apply("R9 +inf", 64'h7FF0_0000_0000_0000, 4'b0010, 0, ONE_P, 0, 0);
    apply("R9 -0 keep", 64'h8000_0000_0000_0000, 4'b0001, 0, ONE_N, 0, 0);
    apply("R9 -0 force+", 64'h8000_0000_0000_0000, 4'b0100, 0, ONE_P, 0, 0);
    apply("R9 -0 reject bit", 64'h8000_0000_0000_0000, 4'b1000, 0, ONE_N, 0, 0);
    apply("R9 -inf keep", 64'hFFF0_0000_0000_0000, 4'b0000, 0, ONE_N, 0, 0);
    apply("R9 -inf force+", 64'hFFF0_0000_0000_0000, 4'b0111, 0, ONE_P, 0, 0);
  endtask

  task automatic test_subnormal();
    apply("R10 min sub int00", 64'h0000_0000_0000_0001, 4'b0000, 0, ONE_P, 0, 1);
    apply("R10 min sub int01 even", 64'h0000_0000_0000_0001, 4'b0001, 0, ONE_P, 0, 1);
    apply("R10 top sub int01 odd", 64'h0008_0000_0000_0000, 4'b0001, 0, 64'h3FE0_0000_0000_0000, 0, 1);
    apply("R10 sub int11", 64'h000C_0000_0000_0000, 4'b0011, 0, 64'h3FE8_0000_0000_0000, 0, 1);
    apply("R10 sub int00", 64'h000C_0000_0000_0000, 4'b0000, 0, 64'h3FF8_0000_0000_0000, 0, 1);
    apply("R10 -sub keep", 64'h800C_0000_0000_0000, 4'b0000, 0, 64'hBFF8_0000_0000_0000, 0, 1);
  endtask

  task automatic test_daz();
    apply("R11 daz +sub", 64'h0008_0000_0000_0000, 4'b0010, 1, ONE_P, 0, 0);
    apply("R11 daz -sub", 64'h8000_0000_0000_0001, 4'b0000, 1, ONE_N, 0, 0);
    apply("R11 daz normal untouched", 64'h3FF8_0000_0000_0000, 4'b0000, 1, 64'h3FF8_0000_0000_0000, 0, 0);
  endtask

  task automatic test_backtoback();
    @(negedge clk);
    inValid = 1'b1; operand = 64'h4008_0000_0000_0000; ctrl = 4'b0001; dazMode = 1'b0;
    @(negedge clk);
    expect_bits("R1 b2b first", {outValid, invalidFlag, denormFlag, result}, {3'b100, 64'h3FE8_0000_0000_0000});
    operand = 64'h7FF0_0000_0000_0001;
    @(negedge clk);
    inValid = 1'b0;
    expect_bits("R1 b2b second", {outValid, invalidFlag, denormFlag, result}, {3'b110, 64'h7FF8_0000_0000_0001});
    @(negedge clk);
    expect_bits("R1 b2b idle", {outValid, invalidFlag, denormFlag, 64'h0}, 67'h0);
  endtask

  initial begin
    test_reset();
    test_intervals();
    test_sign();
    test_nan();
    test_specials();
    test_subnormal();
    test_daz();
    test_backtoback();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule